// File: doc/BRIEF.md
# NOR Flash Erase Sequencer

This block runs one erase operation on a parallel NOR flash device that uses the common two-step unlock command protocol. A single start pulse selects either a whole-device erase or an erase of the sector that contains a given address. The sequencer then writes the six command cycles onto the bus, one per clock. After that it waits for the device to finish.

While it waits, it samples the device ready status at a fixed interval and runs a timeout counter. An erase can be suspended by holding a suspend input high. Polling and the timeout stop while suspend is high. When suspend falls, both restart from their full values.

When the device reports ready, or when the timeout runs out, the sequencer reads one location that the erase should have cleared. If that location is not all ones, it writes a reset command to the device and reports an error. A whole-device erase is refused outright unless it names address zero and a length equal to the full device size.

Top module: `nor_erase_seq`

## Requirements
- R1: After an accepted start, the first five bus write cycles are, in order: 0xAA to unlock address 1, 0x55 to unlock address 2, 0x80 to unlock address 1, 0xAA to unlock address 1, and 0x55 to unlock address 2. One write is issued per clock.
- R2: When `mode_i` is 0 (whole-device erase), the sixth write cycle puts 0x10 on unlock address 1.
- R3: When `mode_i` is 1 (sector erase), the sixth write cycle puts 0x30 on the latched sector address.
- R4: After the sixth write, the ready status is sampled once every POLL_GAP+1 cycles. The first sample is taken in the POLL_GAP+1'th polling cycle. A sample that sees ready ends polling.
- R5: If the device never reports ready, polling ends after TIMEOUT_CYC+1 unsuspended polling cycles.
- R6: While `suspend_i` is high, the sample interval and the timeout are both frozen. The first cycle after `suspend_i` falls reloads both to their full values.
- R7: When polling ends, the sequencer drives a check address for one cycle and samples `rd_data_i`. The check address is unlock address 1 for a whole-device erase and the sector address for a sector erase. If the value read is all ones, `done_o` pulses with `error_o` low.
- R8: If the value read at the check address is not all ones, the sequencer writes 0xF0 to address 0. On the next cycle `done_o` pulses with `error_o` high.
- R9: A timeout alone does not raise `error_o`. The outcome after a timeout is decided only by the all-ones check.
- R10: A whole-device erase request whose address is not 0, or whose length is not DEV_SIZE, is refused. No bus write is issued, `busy_o` stays low, and in the next cycle `done_o` pulses with `error_o` high. A sector erase ignores the length input.
- R11: After reset, `busy_o`, `done_o` and `bus_we_o` are low. `busy_o` is high from the cycle after an accepted start until `done_o` pulses. `done_o` is a one-cycle pulse and is never high together with `busy_o`. `error_o` is meaningful only while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; sampled while idle |
| mode_i | input | 1 | 0 = whole-device erase, 1 = sector erase |
| sect_addr_i | input | AW | Sector address, or the request address for a whole-device erase |
| len_i | input | LW | Request length; checked only for a whole-device erase |
| unlock1_i | input | AW | Unlock address 1 |
| unlock2_i | input | AW | Unlock address 2 |
| dev_ready_i | input | 1 | Device ready status |
| suspend_i | input | 1 | Erase suspended while high |
| rd_data_i | input | DW | Read data at `bus_addr_o` |
| bus_we_o | output | 1 | Bus write strobe |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | DW | Bus write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Failure flag, valid with `done_o` |

## Verification
The hardest case to reach from the ports is a suspend that lands in the middle of polling. The restart only shows if suspend falls after part of the timeout has already been used up. The stimulus therefore counts the six command writes at the falling clock edge, waits a known number of cycles, and holds suspend high for a fixed stretch. The device keeps reporting not-ready, so the busy length shows whether the timeout was reloaded. A ready status raised between two samples, and a timeout followed by a failed check, are each placed at cycle offsets chosen the same way.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CMD,
      S_POLL,
      S_CHECK,
      S_RESET,
      S_FIN
   } seq_state_e;

   typedef enum logic {
      OP_CHIP   = 1'b0,
      OP_SECTOR = 1'b1
   } erase_op_e;

   localparam int unsigned CMD_CYCLES = 6;
   localparam int unsigned STEP_W     = $clog2(CMD_CYCLES);

   localparam logic [7:0] CODE_KEY_A  = 8'hAA;
   localparam logic [7:0] CODE_KEY_B  = 8'h55;
   localparam logic [7:0] CODE_SETUP  = 8'h80;
   localparam logic [7:0] CODE_WHOLE  = 8'h10;
   localparam logic [7:0] CODE_SECTOR = 8'h30;
   localparam logic [7:0] CODE_RESET  = 8'hF0;

endpackage

// File: rtl/nor_cmd_table.sv
module nor_cmd_table
   import nor_erase_pkg::*;
#(
   parameter int unsigned AW = 24,
   parameter int unsigned DW = 16
) (
   input  logic [STEP_W-1:0] step_i,
   input  erase_op_e         op_i,
   input  logic [AW-1:0]     unlock1_i,
   input  logic [AW-1:0]     unlock2_i,
   input  logic [AW-1:0]     sect_i,
   output logic [AW-1:0]     addr_o,
   output logic [DW-1:0]     data_o
);

   logic [7:0] code;

   always_comb begin
      addr_o = '0;
      code   = 8'h00;
      unique case (step_i)
         3'd0: begin addr_o = unlock1_i; code = CODE_KEY_A; end
         3'd1: begin addr_o = unlock2_i; code = CODE_KEY_B; end
         3'd2: begin addr_o = unlock1_i; code = CODE_SETUP; end
         3'd3: begin addr_o = unlock1_i; code = CODE_KEY_A; end
         3'd4: begin addr_o = unlock2_i; code = CODE_KEY_B; end
         3'd5: begin
            if (op_i == OP_SECTOR) begin
               addr_o = sect_i;
               code   = CODE_SECTOR;
            end else begin
               addr_o = unlock1_i;
               code   = CODE_WHOLE;
            end
         end
         default: begin addr_o = '0; code = 8'h00; end
      endcase
   end

   generate
      if (DW > 8) begin : g_pad
         assign data_o = {{(DW-8){1'b0}}, code};
      end else begin : g_narrow
         assign data_o = code;
      end
   endgenerate

endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
   parameter longint unsigned TIMEOUT_CYC = 64'd5_000_000_000,
   parameter int unsigned     POLL_GAP    = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic run_i,
   input  logic hold_i,
   output logic sample_o,
   output logic expired_o
);

   localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
   localparam int unsigned GW = $clog2(POLL_GAP + 1);
   localparam logic [TW-1:0] TO_LOAD  = TW'(TIMEOUT_CYC);
   localparam logic [GW-1:0] GAP_LOAD = GW'(POLL_GAP);

   logic [TW-1:0] to_q;
   logic [GW-1:0] gap_q;
   logic          resume_q;
   logic          live;

   assign live      = run_i && !hold_i && !resume_q;
   assign sample_o  = live && (gap_q == '0);
   assign expired_o = live && (to_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_q     <= '0;
         gap_q    <= '0;
         resume_q <= 1'b0;
      end else if (arm_i) begin
         to_q     <= TO_LOAD;
         gap_q    <= GAP_LOAD;
         resume_q <= 1'b0;
      end else if (run_i) begin
         if (hold_i) begin
            resume_q <= 1'b1;
         end else if (resume_q) begin
            to_q     <= TO_LOAD;
            gap_q    <= GAP_LOAD;
            resume_q <= 1'b0;
         end else begin
            if (to_q != '0) to_q <= to_q - TW'(1);
            if (gap_q == '0) gap_q <= GAP_LOAD;
            else             gap_q <= gap_q - GW'(1);
         end
      end
   end

   // R6
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && hold_i && !arm_i) |=> ($stable(to_q) && $stable(gap_q)));

   // R6
   resume_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !hold_i && resume_q && !arm_i) |=> (to_q == TO_LOAD && gap_q == GAP_LOAD));

   // R5
   countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !arm_i && to_q != '0) |=> (to_q == $past(to_q) - TW'(1)));

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
   import nor_erase_pkg::*;
#(
   parameter int unsigned     AW          = 24,
   parameter int unsigned     DW          = 16,
   parameter int unsigned     LW          = AW + 1,
   parameter longint unsigned DEV_SIZE    = 64'd16_777_216,
   parameter longint unsigned TIMEOUT_CYC = 64'd5_000_000_000,
   parameter int unsigned     POLL_GAP    = 250
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          mode_i,
   input  logic [AW-1:0] sect_addr_i,
   input  logic [LW-1:0] len_i,
   input  logic [AW-1:0] unlock1_i,
   input  logic [AW-1:0] unlock2_i,
   input  logic          dev_ready_i,
   input  logic          suspend_i,
   input  logic [DW-1:0] rd_data_i,
   output logic          bus_we_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          error_o
);

   localparam logic [LW-1:0]     FULL_LEN  = LW'(DEV_SIZE);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CMD_CYCLES - 1);

   generate
      if (DW < 8) begin : g_bad_dw
         $error("nor_erase_seq: DW must be at least 8");
      end
      if (POLL_GAP < 1) begin : g_bad_gap
         $error("nor_erase_seq: POLL_GAP must be at least 1");
      end
      if (TIMEOUT_CYC < 1) begin : g_bad_to
         $error("nor_erase_seq: TIMEOUT_CYC must be at least 1");
      end
      if (LW <= AW) begin : g_bad_lw
         $error("nor_erase_seq: LW must exceed AW");
      end
   endgenerate

   seq_state_e        state_q;
   logic [STEP_W-1:0] step_q;
   erase_op_e         op_q;
   logic [AW-1:0]     sect_q;
   logic              fail_q;

   logic          refuse;
   logic          arm;
   logic          run;
   logic          sample;
   logic          expired;
   logic [AW-1:0] tbl_addr;
   logic [DW-1:0] tbl_data;
   logic [AW-1:0] chk_addr;

   assign refuse   = (erase_op_e'(mode_i) == OP_CHIP) &&
                     ((sect_addr_i != '0) || (len_i != FULL_LEN));
   assign arm      = (state_q == S_CMD) && (step_q == LAST_STEP);
   assign run      = (state_q == S_POLL);
   assign chk_addr = (op_q == OP_SECTOR) ? sect_q : unlock1_i;

   nor_cmd_table #(.AW(AW), .DW(DW)) u_table (
      .step_i    (step_q),
      .op_i      (op_q),
      .unlock1_i (unlock1_i),
      .unlock2_i (unlock2_i),
      .sect_i    (sect_q),
      .addr_o    (tbl_addr),
      .data_o    (tbl_data)
   );

   nor_poll_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .POLL_GAP(POLL_GAP)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (arm),
      .run_i     (run),
      .hold_i    (suspend_i),
      .sample_o  (sample),
      .expired_o (expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         step_q  <= '0;
         op_q    <= OP_CHIP;
         sect_q  <= '0;
         fail_q  <= 1'b0;
      end else begin
         unique case (state_q)
            S_IDLE: begin
               if (start_i) begin
                  op_q   <= erase_op_e'(mode_i);
                  sect_q <= sect_addr_i;
                  step_q <= '0;
                  if (refuse) begin
                     fail_q  <= 1'b1;
                     state_q <= S_FIN;
                  end else begin
                     fail_q  <= 1'b0;
                     state_q <= S_CMD;
                  end
               end
            end
            S_CMD: begin
               if (step_q == LAST_STEP) state_q <= S_POLL;
               else                     step_q  <= step_q + STEP_W'(1);
            end
            S_POLL: begin
               if (expired || (sample && dev_ready_i)) state_q <= S_CHECK;
            end
            S_CHECK: begin
               if (rd_data_i == '1) begin
                  state_q <= S_FIN;
               end else begin
                  fail_q  <= 1'b1;
                  state_q <= S_RESET;
               end
            end
            S_RESET: state_q <= S_FIN;
            S_FIN:   state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_we_o    = 1'b0;
      bus_addr_o  = '0;
      bus_wdata_o = '0;
      unique case (state_q)
         S_CMD: begin
            bus_we_o    = 1'b1;
            bus_addr_o  = tbl_addr;
            bus_wdata_o = tbl_data;
         end
         S_CHECK: bus_addr_o = chk_addr;
         S_RESET: begin
            bus_we_o    = 1'b1;
            bus_wdata_o = DW'(CODE_RESET);
         end
         default: ;
      endcase
   end

   assign busy_o  = (state_q == S_CMD) || (state_q == S_POLL) ||
                    (state_q == S_CHECK) || (state_q == S_RESET);
   assign done_o  = (state_q == S_FIN);
   assign error_o = done_o && fail_q;

   // R1
   step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_CMD && step_q != LAST_STEP) |=>
      (bus_we_o && step_q == $past(step_q) + STEP_W'(1)));

   // R8
   reset_then_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_RESET) |=> (done_o && error_o));

   // R10
   refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && start_i && refuse) |=> (done_o && error_o && !bus_we_o && !busy_o));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R11
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R11
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && start_i && !refuse) |=> busy_o);

endmodule

// File: tb/nor_erase_seq_tb.sv
module nor_erase_seq_tb;
   import nor_erase_pkg::*;

   localparam int unsigned     AW   = 16;
   localparam int unsigned     DW   = 16;
   localparam int unsigned     LW   = 17;
   localparam longint unsigned DEV  = 64'd65536;
   localparam longint unsigned TO   = 64'd40;
   localparam int unsigned     GAP  = 3;
   localparam logic [AW-1:0]   U1   = 16'h0555;
   localparam logic [AW-1:0]   U2   = 16'h02AA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          mode_i = 1'b0;
   logic [AW-1:0] sect_addr_i = '0;
   logic [LW-1:0] len_i = '0;
   logic          dev_ready_i = 1'b0;
   logic          suspend_i = 1'b0;
   logic [DW-1:0] rd_data_i;
   logic          bus_we_o;
   logic [AW-1:0] bus_addr_o;
   logic [DW-1:0] bus_wdata_o;
   logic          busy_o;
   logic          done_o;
   logic          error_o;

   logic [AW-1:0] chk_addr_tb = '0;
   logic [DW-1:0] rd_val_tb = '0;

   always #2 clk = ~clk;

   assign rd_data_i = (bus_addr_o == chk_addr_tb) ? rd_val_tb : '0;

   nor_erase_seq #(
      .AW(AW), .DW(DW), .LW(LW), .DEV_SIZE(DEV), .TIMEOUT_CYC(TO), .POLL_GAP(GAP)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .sect_addr_i(sect_addr_i), .len_i(len_i), .unlock1_i(U1), .unlock2_i(U2),
      .dev_ready_i(dev_ready_i), .suspend_i(suspend_i), .rd_data_i(rd_data_i),
      .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
      .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
   );

   typedef struct packed {
      logic [AW-1:0] a;
      logic [DW-1:0] d;
   } wr_t;

   typedef struct packed {
      logic        err;
      logic [31:0] cyc;
   } out_t;

   wr_t   exp_wr[$];
   string exp_wr_tag[$];
   out_t  exp_out[$];
   string exp_out_tag[$];

   int n_vec = 0;
   int n_bad = 0;
   int busy_cnt = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   // Monitor: pops expected writes and outcomes as the design produces them
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy_o) busy_cnt++;
         if (bus_we_o) begin
            if (exp_wr.size() == 0) begin
               chk(1'b0, "R1", "unexpected bus write addr", longint'(bus_addr_o), 0);
            end else begin
               wr_t   w;
               string t;
               w = exp_wr.pop_front();
               t = exp_wr_tag.pop_front();
               chk(bus_addr_o == w.a, t, "write address", longint'(bus_addr_o), longint'(w.a));
               chk(bus_wdata_o == w.d, t, "write data", longint'(bus_wdata_o), longint'(w.d));
            end
         end
         if (done_o) begin
            if (exp_out.size() == 0) begin
               chk(1'b0, "R11", "unexpected done", 1, 0);
            end else begin
               out_t  o;
               string t;
               o = exp_out.pop_front();
               t = exp_out_tag.pop_front();
               chk(error_o == o.err, t, "error flag", longint'(error_o), longint'(o.err));
               chk(busy_cnt == int'(o.cyc), t, "busy cycles", busy_cnt, longint'(o.cyc));
               chk(exp_wr.size() == 0, t, "writes missing", exp_wr.size(), 0);
            end
            busy_cnt = 0;
         end
      end
   end

   // Driver: pushes expectations and runs one operation
   task automatic run_op(input logic op, input logic [AW-1:0] sect, input logic [LW-1:0] len,
                         input int ready_at, input logic [DW-1:0] rdv,
                         input int susp_j, input int susp_s,
                         input bit refused, input int exp_cyc, input string tag);
      bit will_fail;
      int n;
      will_fail = refused || (rdv != '1);
      if (!refused) begin
         exp_wr.push_back('{a: U1, d: 16'h00AA}); exp_wr_tag.push_back("R1");
         exp_wr.push_back('{a: U2, d: 16'h0055}); exp_wr_tag.push_back("R1");
         exp_wr.push_back('{a: U1, d: 16'h0080}); exp_wr_tag.push_back("R1");
         exp_wr.push_back('{a: U1, d: 16'h00AA}); exp_wr_tag.push_back("R1");
         exp_wr.push_back('{a: U2, d: 16'h0055}); exp_wr_tag.push_back("R1");
         if (op) begin
            exp_wr.push_back('{a: sect, d: 16'h0030}); exp_wr_tag.push_back("R3");
         end else begin
            exp_wr.push_back('{a: U1, d: 16'h0010}); exp_wr_tag.push_back("R2");
         end
         if (will_fail) begin
            exp_wr.push_back('{a: '0, d: 16'h00F0}); exp_wr_tag.push_back("R8");
         end
      end
      exp_out.push_back('{err: will_fail, cyc: 32'(exp_cyc)});
      exp_out_tag.push_back(tag);
      chk_addr_tb = op ? sect : U1;
      rd_val_tb   = rdv;
      dev_ready_i = (ready_at == 0);
      @(negedge clk);
      mode_i      = op;
      sect_addr_i = sect;
      len_i       = len;
      start_i     = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (!refused) begin
         n = bus_we_o ? 1 : 0;
         while (n < 6) begin
            @(negedge clk);
            if (bus_we_o) n++;
         end
         if (ready_at > 0) begin
            repeat (ready_at) @(negedge clk);
            dev_ready_i = 1'b1;
         end
         if (susp_j > 0) begin
            repeat (susp_j) @(negedge clk);
            suspend_i = 1'b1;
            repeat (susp_s) @(negedge clk);
            suspend_i = 1'b0;
         end
      end
      while (!done_o) @(negedge clk);
      @(negedge clk);
      dev_ready_i = 1'b0;
      chk(!busy_o && !done_o, tag, "idle after done", longint'({busy_o, done_o}), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(!busy_o && !done_o && !bus_we_o, "R11", "reset outputs",
          longint'({busy_o, done_o, bus_we_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R4 R7: whole-device erase, ready on first sample
      run_op(1'b0, '0, 17'(DEV), 0, 16'hFFFF, 0, 0, 1'b0, 6 + GAP + 1 + 1, "R4");
      // R3 R7: sector erase, check at sector address
      run_op(1'b1, 16'h1230, 17'd5, 0, 16'hFFFF, 0, 0, 1'b0, 6 + GAP + 1 + 1, "R7");
      // R4: ready raised between samples is seen at the second sample
      run_op(1'b1, 16'h4000, '0, 6, 16'hFFFF, 0, 0, 1'b0, 6 + 2 * (GAP + 1) + 1, "R4");
      // R5 R9: timeout, location erased -> no error
      run_op(1'b0, '0, 17'(DEV), -1, 16'hFFFF, 0, 0, 1'b0, 6 + int'(TO) + 1 + 1, "R9");
      // R8 R9: timeout, location not erased -> reset command, error
      run_op(1'b1, 16'h0800, '0, -1, 16'h00FF, 0, 0, 1'b0, 6 + int'(TO) + 1 + 1 + 1, "R8");
      // R8: ready but check fails
      run_op(1'b0, '0, 17'(DEV), 0, 16'hFFFE, 0, 0, 1'b0, 6 + GAP + 1 + 1 + 1, "R8");
      // R6: suspend mid-poll for 7 cycles, timeout restarts in full
      run_op(1'b1, 16'h2200, '0, -1, 16'hFFFF, 5, 7, 1'b0, int'(TO) + 5 + 7 + 8, "R6");
      // R10: whole-device erase with nonzero address refused
      run_op(1'b0, 16'h0004, 17'(DEV), 0, 16'hFFFF, 0, 0, 1'b1, 0, "R10");
      // R10: whole-device erase with short length refused
      run_op(1'b0, '0, 17'(DEV - 1), 0, 16'hFFFF, 0, 0, 1'b1, 0, "R10");
      // R10: sector erase ignores length
      run_op(1'b1, 16'h8000, 17'd3, 0, 16'hFFFF, 0, 0, 1'b0, 6 + GAP + 1 + 1, "R10");

      repeat (3) @(negedge clk);
      chk(exp_out.size() == 0, "R11", "outcomes pending", exp_out.size(), 0);
      finish_run();
   end

endmodule